// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a two-channel serial audio stream into parallel sample pairs. The bit clock, the word-select (frame) clock and the data line are all treated as ordinary inputs and sampled in one fast system clock domain. Bit-clock edges are found there, and each bit is placed into a 24-bit word according to the framing format chosen by a 3-bit code.

Three kinds of framing are supported. In MSB-justified framing the word starts at the first bit of a half-frame. In the I2S-style framing the word starts one bit later. In LSB-justified framing at 16, 20 or 24 bits the word ends on the last bit of a half-frame, so its position depends on where the half-frame ends. The half-frame length follows the frame clock and is not fixed, so bit clocks of 32, 48 and 64 times the frame rate all work.

When a right-channel word is complete, the block presents the stored left word and the right word together with a one-cycle valid pulse. Words shorter than 24 bits are left-aligned, and zero fills the bits below them.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high, and after it, `valid_o` is low and both sample outputs are zero. No pair is produced until one full left half-frame and then one full right half-frame have been received, both starting after the first frame-clock transition seen since reset.
- R2: A data bit is taken from `sd_i` at each rising edge of `bclk_i`, and the most significant bit is sent first. A pair only ever appears in response to a detected bit-clock rising edge.
- R3: With code 3'b010, and with any code from 3'b101 to 3'b111, slot 0 of a half-frame (the first bit after the frame-clock change) is output bit 23 and slot k is bit 23-k for k<24. Slots from 24 onward are ignored. When the half-frame has fewer than 24 slots, the bits that were never received are zero.
- R4: With code 3'b011, the word's MSB is in slot 1 and slot k is bit 24-k for k from 1 to 24. Slot 0 and slots after 24 are ignored, and bits never received are zero. In this mode the left channel is the half-frame in which `ws_i` is low.
- R5: With code 3'b000, the last 16 slots of a half-frame form a 16-bit word that appears on output bits 23..8, and bits 7..0 are zero. Earlier slots are ignored.
- R6: With code 3'b001, the last 20 slots form a word on output bits 23..4, and bits 3..0 are zero. Earlier slots are ignored.
- R7: With code 3'b100, the last 24 slots form the full 24-bit word. Earlier slots are ignored.
- R8: For every code other than 3'b011, the left channel is the half-frame in which `ws_i` is high.
- R9: `valid_o` is high for exactly one system clock cycle per frame. It rises after the right word is finished, at the first bit-clock rising edge of the next half-frame. The outputs hold their values between pulses.
- R10: Codes 3'b101, 3'b110 and 3'b111 are received exactly as code 3'b010.
- R11: The half-frame length comes from the frame clock. Bit clocks of 32, 48 and 64 times the frame rate are accepted, provided each half-frame holds at least as many slots as the word has bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all stream inputs |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 3 | Framing format code |
| bclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Frame (word-select) clock |
| sd_i | input | 1 | Serial data line |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
If the slot counter drifts by a single bit, every word in the affected half-frame comes out shifted by one place: a doubled or halved sample, or a lost LSB. This shows at the ports on the first pair after the fault. If the channel-polarity or pairing state is wrong, left and right swap, or a pulse is dropped or doubled, within one frame. The directed extremes (most negative, most positive, a lone LSB) are chosen so that a shift in either direction, a sign-bit error or a missing zero fill changes the expected pair.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int AW = 24;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'b000,
        FMT_LSB20 = 3'b001,
        FMT_MSB24 = 3'b010,
        FMT_DLY24 = 3'b011,
        FMT_LSB24 = 3'b100
    } fmt_code_e;

    typedef struct packed {
        logic rise;
        logic ws;
        logic sd;
    } bit_evt_t;

    typedef struct packed {
        logic       lsb_just;
        logic [4:0] width;
        logic       msb_delay;
        logic       left_lvl;
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.lsb_just  = 1'b0;
        c.width     = 5'd24;
        c.msb_delay = 1'b0;
        c.left_lvl  = 1'b1;
        case (code)
            FMT_LSB16: begin c.lsb_just = 1'b1; c.width = 5'd16; end
            FMT_LSB20: begin c.lsb_just = 1'b1; c.width = 5'd20; end
            FMT_LSB24: begin c.lsb_just = 1'b1; c.width = 5'd24; end
            FMT_DLY24: begin c.msb_delay = 1'b1; c.left_lvl = 1'b0; end
            default:   ;
        endcase
        return c;
    endfunction

    function automatic logic [AW-1:0] align_lsb(input logic [AW-1:0] sr,
                                                 input logic [4:0]    width);
        logic [5:0] sh;
        sh = 6'(AW) - {1'b0, width};
        return sr << sh;
    endfunction

endpackage

// File: rtl/aud_rx_sampler.sv
module aud_rx_sampler
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_i,
    input  logic     ws_i,
    input  logic     sd_i,
    output bit_evt_t evt_o
);
    // each stage holds {bclk, ws, sd}
    logic [SYNC_STAGES:0][2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[SYNC_STAGES-1:0], {bclk_i, ws_i, sd_i}};
    end

    always_comb begin
        evt_o.rise = pipe[SYNC_STAGES-1][2] & ~pipe[SYNC_STAGES][2];
        evt_o.ws   = pipe[SYNC_STAGES-1][1];
        evt_o.sd   = pipe[SYNC_STAGES-1][0];
    end
endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_evt_t         evt_i,
    output logic             boundary_o,
    output logic [CNT_W-1:0] slot_o,
    output logic             ended_lvl_o,
    output logic             ended_ok_o
);
    logic             have_ws;
    logic             ws_q;
    logic             synced;
    logic [CNT_W-1:0] slot_q;

    assign boundary_o  = evt_i.rise && have_ws && (evt_i.ws != ws_q);
    assign slot_o      = boundary_o ? '0 : slot_q;
    assign ended_lvl_o = ws_q;
    assign ended_ok_o  = synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_ws <= 1'b0;
            ws_q    <= 1'b0;
            synced  <= 1'b0;
            slot_q  <= '0;
        end else if (evt_i.rise) begin
            if (!have_ws) begin
                have_ws <= 1'b1;
                ws_q    <= evt_i.ws;
                slot_q  <= CNT_W'(1);
            end else if (boundary_o) begin
                ws_q    <= evt_i.ws;
                slot_q  <= CNT_W'(1);
                synced  <= 1'b1;
            end else if (slot_q != '1) begin
                slot_q  <= slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_evt_t         evt_i,
    input  logic             boundary_i,
    input  logic [CNT_W-1:0] slot_i,
    input  fmt_cfg_t         cfg_i,
    output logic [AW-1:0]    word_o
);
    logic [AW-1:0]    tail_sr;
    logic [AW-1:0]    head_acc;
    logic [AW-1:0]    head_next;
    logic [CNT_W-1:0] idx;
    logic             hit;

    // word of the half-frame that ends at this boundary
    assign word_o = cfg_i.lsb_just ? align_lsb(tail_sr, cfg_i.width) : head_acc;

    always_comb begin
        hit       = slot_i >= CNT_W'(cfg_i.msb_delay);
        idx       = slot_i - CNT_W'(cfg_i.msb_delay);
        head_next = boundary_i ? '0 : head_acc;
        for (int b = 0; b < AW; b++) begin
            if (hit && idx == CNT_W'(AW - 1 - b)) head_next[b] = evt_i.sd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_sr  <= '0;
            head_acc <= '0;
        end else if (evt_i.rise) begin
            tail_sr  <= {tail_sr[AW-2:0], evt_i.sd};
            head_acc <= head_next;
        end
    end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_SLOTS   = 128,
    localparam int CNT_W      = $clog2(MAX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    fmt_i,
    input  logic          bclk_i,
    input  logic          ws_i,
    input  logic          sd_i,
    output logic [AW-1:0] left_o,
    output logic [AW-1:0] right_o,
    output logic          valid_o
);
    bit_evt_t         evt;
    fmt_cfg_t         cfg;
    logic             boundary;
    logic [CNT_W-1:0] slot;
    logic             ended_lvl;
    logic             ended_ok;
    logic [AW-1:0]    word;
    logic             bit_rise;
    logic [AW-1:0]    left_hold;
    logic             left_ok;
    logic             word_rdy;
    logic             ended_left;

    assign cfg      = decode_fmt(fmt_i);
    assign bit_rise = evt.rise;

    aud_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst(rst), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
        .evt_o(evt)
    );

    aud_rx_slot #(.CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst(rst), .evt_i(evt), .boundary_o(boundary),
        .slot_o(slot), .ended_lvl_o(ended_lvl), .ended_ok_o(ended_ok)
    );

    aud_rx_word #(.CNT_W(CNT_W)) u_word (
        .clk(clk), .rst(rst), .evt_i(evt), .boundary_i(boundary),
        .slot_i(slot), .cfg_i(cfg), .word_o(word)
    );

    assign word_rdy   = boundary && ended_ok;
    assign ended_left = (ended_lvl == cfg.left_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_rdy) begin
                if (ended_left) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_o  <= left_hold;
                    right_o <= word;
                    valid_o <= 1'b1;
                    left_ok <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  fmt_i,
    input logic        rise,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        valid_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && left_o == '0 && right_o == '0));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R2
    needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(rise));

    // R5
    lsb16_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(fmt_i) == 3'b000) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0));

    // R6
    lsb20_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(fmt_i) == 3'b001) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0));
endmodule

bind audio_serial_rx aud_rx_chk u_chk (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .rise(bit_rise),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = 3'b010;
    logic        bclk = 1'b0;
    logic        ws = 1'b0;
    logic        sd = 1'b0;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int          n_chk = 0;
    int          n_fail = 0;
    int          got_valid = 0;
    logic        prev_v = 1'b0;
    logic [47:0] expq[$];
    logic [47:0] e;
    string       cur_req = "R1";

    always #5 clk = ~clk;

    audio_serial_rx dut (
        .clk(clk), .rst(rst), .fmt_i(fmt), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected 24-bit output for a transmitted word w with hl slots per half
    function automatic logic [23:0] exp_word(input logic [2:0] code, input int hl,
                                             input logic [23:0] w);
        int n;
        logic [23:0] m;
        case (code)
            3'b000: return {w[23:8], 8'd0};
            3'b001: return {w[23:4], 4'd0};
            3'b100: return w;
            3'b011: n = (hl - 1 < 24) ? hl - 1 : 24;
            default: n = (hl < 24) ? hl : 24;
        endcase
        m = (n >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> n);
        return w & m;
    endfunction

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        ws = w; sd = d; bclk = 1'b0;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic [2:0] code, input int hl, input logic lvl,
                             input logic [23:0] w);
        for (int s = 0; s < hl; s++) begin
            logic b;
            int wd;
            b = 1'($urandom);
            wd = (code == 3'b000) ? 16 : (code == 3'b001) ? 20 : 24;
            if (code == 3'b000 || code == 3'b001 || code == 3'b100) begin
                if (s >= hl - wd) b = w[23 - (s - (hl - wd))];
            end else if (code == 3'b011) begin
                if (s >= 1 && s <= 24) b = w[24 - s];
            end else begin
                if (s < 24) b = w[23 - s];
            end
            send_bit(lvl, b);
        end
    endtask

    task automatic run_seg(input logic [2:0] code, input int hl, input int nfr,
                           input string req);
        logic lvl_l;
        logic [23:0] l, r;
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0; fmt = code;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!valid_o && left_o == 24'd0 && right_o == 24'd0, "R1", "reset state",
              {left_o, right_o}, 48'd0);
        cur_req = req;
        got_valid = 0;
        lvl_l = (code == 3'b011) ? 1'b0 : 1'b1;
        send_half(code, hl, ~lvl_l, 24'($urandom));
        for (int f = 0; f < nfr; f++) begin
            if (f == 0)      begin l = 24'h800000; r = 24'h7FFFFF; end
            else if (f == 1) begin l = 24'h000001; r = 24'hFFFFFE; end
            else             begin l = 24'($urandom); r = 24'($urandom); end
            expq.push_back({exp_word(code, hl, l), exp_word(code, hl, r)});
            send_half(code, hl, lvl_l, l);
            // R1: nothing yet after the first left half
            if (f == 0) check(got_valid == 0, "R1", "early pair", 48'(got_valid), 48'd0);
            send_half(code, hl, ~lvl_l, r);
        end
        send_half(code, hl, lvl_l, 24'($urandom));
        repeat (8) @(negedge clk);
        check(got_valid == nfr, "R9", "pulse count", 48'(got_valid), 48'(nfr));
        check(expq.size() == 0, "R9", "missing pairs", 48'(expq.size()), 48'd0);
        expq.delete();
    endtask

    always @(negedge clk) begin
        if (!rst && valid_o) begin
            got_valid++;
            if (prev_v) check(1'b0, "R9", "double pulse", 48'd1, 48'd0);
            if (expq.size() == 0) begin
                check(1'b0, "R9", "unexpected pair", {left_o, right_o}, 48'd0);
            end else begin
                e = expq.pop_front();
                check({left_o, right_o} == e, cur_req, "pair", {left_o, right_o}, e);
            end
        end
        prev_v = valid_o;
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", "run hung", 48'd0, 48'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2 is exercised by every pair: bits taken at bit-clock rises, MSB first
        run_seg(3'b010, 32, 6, "R2 R3 R8");
        run_seg(3'b010, 24, 5, "R3 R11");
        run_seg(3'b010, 16, 5, "R3 R11");
        run_seg(3'b011, 32, 6, "R4");
        run_seg(3'b011, 24, 5, "R4 R11");
        run_seg(3'b000, 16, 5, "R5 R11");
        run_seg(3'b000, 32, 5, "R5");
        run_seg(3'b001, 20, 5, "R6 R11");
        run_seg(3'b001, 32, 5, "R6");
        run_seg(3'b100, 24, 5, "R7 R11");
        run_seg(3'b100, 32, 5, "R7");
        run_seg(3'b101, 32, 4, "R10");
        run_seg(3'b111, 32, 4, "R10");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule